// File: doc/BRIEF.md
# Delayed-Branch Program Counter Unit

This unit holds the fetch-side program counter of a pipelined 32-bit processor whose branches have one delay slot. It keeps two address registers: the address of the instruction now executing (current PC) and the address of the instruction that follows it (next PC). A decoded branch request describes the instruction at the current PC. When that branch is taken, only the next PC is redirected. The instruction already sitting after the branch therefore still executes before control reaches the target.

Three branch kinds are accepted. The first is an unconditional PC-relative branch that also writes a return address. The second is a branch through a register operand. The third is a PC-relative branch taken only when an immediate compared against a register comes out false. For the linking kind, the unit issues a one-cycle write of the return address to general register 2. That address skips the delay slot, so a later branch through register 2 resumes after the slot. A stall input freezes the unit.

Top module: `dbr_pc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the current PC becomes `RESET_VEC`, the next PC becomes `RESET_VEC + 4`, and `link_we` becomes 0.
- R2: On a non-stalled edge with no taken branch, the next PC becomes its old value plus 4.
- R3: On every non-stalled edge the current PC takes the old next PC. A taken branch changes only the next PC, so the delay-slot instruction always follows the branch.
- R4: Branch kind 1 (branch-and-link) is always taken, with target = current PC + `br_disp` (byte displacement, two's complement).
- R5: On a non-stalled edge with kind 1, the next cycle shows `link_we` = 1, `link_idx` = 2 and `link_data` = branch address + 8. In every other cycle `link_we` is 0.
- R6: Branch kind 2 (vectored) is always taken, with target = `br_reg` with bits 1:0 cleared.
- R7: Branch kind 3 (compare and branch if false) is taken, with target = current PC + `br_disp`, only when `cmp_imm` differs from `cmp_reg`. When the two are equal, it acts as kind 0 (no branch).
- R8: While `stall` is high, both PC registers keep their values and no link write is issued in the following cycle.
- R9: A branch in the delay slot of a taken branch uses the same update rule, with no special case.
- R10: `fetch_pc` always equals the next PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Freeze both PC registers and suppress link writes |
| br_kind | input | 2 | 0 none, 1 branch-and-link, 2 vectored, 3 compare-and-branch-if-false |
| br_disp | input | 32 | Signed byte displacement for kinds 1 and 3 |
| br_reg | input | 32 | Register operand giving the vectored target |
| cmp_imm | input | 32 | Immediate operand of the comparison |
| cmp_reg | input | 32 | Register operand of the comparison |
| fetch_pc | output | 32 | Address to fetch next |
| cur_pc | output | 32 | Address of the instruction now executing |
| nxt_pc | output | 32 | Address of the instruction after it |
| link_we | output | 1 | Link write strobe |
| link_idx | output | 5 | Register index of the link write |
| link_data | output | 32 | Return address written |

## Verification
The assertions assume that the branch fields describe the instruction at the current PC. They also assume that displacements and the reset vector are multiples of 4, so every address stays word aligned. The stimulus uses only aligned displacements. It feeds a vectored operand with its low bits set, to check that the masking happens inside the unit. The stall and reset inputs are changed only between clock edges, so every property sees a clean, settled input value.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  localparam int unsigned XLEN = 32;
  localparam int unsigned RIDX = 5;

  typedef enum logic [1:0] {
    BK_NONE = 2'd0,
    BK_LINK = 2'd1,
    BK_VEC  = 2'd2,
    BK_CMPF = 2'd3
  } br_kind_e;
endpackage

// File: rtl/dbr_target.sv
module dbr_target
  import dbr_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  br_kind_e       kind,
  input  logic [W-1:0]   pc,
  input  logic [W-1:0]   disp,
  input  logic [W-1:0]   vreg,
  input  logic [W-1:0]   imm,
  input  logic [W-1:0]   creg,
  output logic           taken,
  output logic           is_link,
  output logic [W-1:0]   target
);
  localparam logic [W-1:0] ALIGN_MASK = ~{{(W-2){1'b0}}, 2'b11};

  logic [W-1:0] rel_tgt;
  logic         cmp_false;

  assign rel_tgt   = pc + disp;
  assign cmp_false = (imm != creg);

  always_comb begin
    taken   = 1'b0;
    is_link = 1'b0;
    target  = rel_tgt;
    unique case (kind)
      BK_LINK: begin
        taken   = 1'b1;
        is_link = 1'b1;
      end
      BK_VEC: begin
        taken  = 1'b1;
        target = vreg & ALIGN_MASK;
      end
      BK_CMPF: taken = cmp_false;
      default: taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/dbr_pc_regs.sv
module dbr_pc_regs
  import dbr_pkg::*;
#(
  parameter int unsigned   W         = XLEN,
  parameter logic [W-1:0]  RESET_VEC = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         stall,
  input  logic         taken,
  input  logic [W-1:0] target,
  output logic [W-1:0] cur_q,
  output logic [W-1:0] nxt_q
);
  localparam logic [W-1:0] STEP = W'(4);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= RESET_VEC;
      nxt_q <= RESET_VEC + STEP;
    end else if (!stall) begin
      cur_q <= nxt_q;
      nxt_q <= taken ? target : nxt_q + STEP;
    end
  end

  // R3
  adv_chk: assert property (@(posedge clk) disable iff (rst)
    !stall |=> cur_q == $past(nxt_q));

  // R2
  seq_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && !taken) |=> nxt_q == $past(nxt_q) + STEP);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> ($stable(cur_q) && $stable(nxt_q)));
endmodule

// File: rtl/dbr_link_reg.sv
module dbr_link_reg
  import dbr_pkg::*;
#(
  parameter int unsigned W        = XLEN,
  parameter int unsigned LINK_IDX = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fire,
  input  logic [W-1:0]    pc,
  output logic            we_q,
  output logic [RIDX-1:0] idx,
  output logic [W-1:0]    data_q
);
  localparam logic [W-1:0] SKIP = W'(8);

  assign idx = RIDX'(LINK_IDX);

  generate
    if (LINK_IDX == 0) begin : g_zero_sink
      assign we_q   = 1'b0;
      assign data_q = '0;
    end else begin : g_live
      logic         we_r;
      logic [W-1:0] data_r;
      always_ff @(posedge clk) begin
        if (rst) begin
          we_r   <= 1'b0;
          data_r <= '0;
        end else begin
          we_r <= fire;
          if (fire) data_r <= pc + SKIP;
        end
      end
      assign we_q   = we_r;
      assign data_q = data_r;
    end
  endgenerate
endmodule

// File: rtl/dbr_pc_unit.sv
module dbr_pc_unit
  import dbr_pkg::*;
#(
  parameter int unsigned  W         = XLEN,
  parameter logic [W-1:0] RESET_VEC = '0,
  parameter int unsigned  LINK_IDX  = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stall,
  input  logic [1:0]      br_kind,
  input  logic [W-1:0]    br_disp,
  input  logic [W-1:0]    br_reg,
  input  logic [W-1:0]    cmp_imm,
  input  logic [W-1:0]    cmp_reg,
  output logic [W-1:0]    fetch_pc,
  output logic [W-1:0]    cur_pc,
  output logic [W-1:0]    nxt_pc,
  output logic            link_we,
  output logic [RIDX-1:0] link_idx,
  output logic [W-1:0]    link_data
);
  logic         taken;
  logic         is_link;
  logic [W-1:0] target;

  dbr_target #(.W(W)) u_tgt (
    .kind    (br_kind_e'(br_kind)),
    .pc      (cur_pc),
    .disp    (br_disp),
    .vreg    (br_reg),
    .imm     (cmp_imm),
    .creg    (cmp_reg),
    .taken   (taken),
    .is_link (is_link),
    .target  (target)
  );

  dbr_pc_regs #(.W(W), .RESET_VEC(RESET_VEC)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .stall  (stall),
    .taken  (taken),
    .target (target),
    .cur_q  (cur_pc),
    .nxt_q  (nxt_pc)
  );

  dbr_link_reg #(.W(W), .LINK_IDX(LINK_IDX)) u_link (
    .clk    (clk),
    .rst    (rst),
    .fire   (is_link && !stall),
    .pc     (cur_pc),
    .we_q   (link_we),
    .idx    (link_idx),
    .data_q (link_data)
  );

  assign fetch_pc = nxt_pc;

  // R5
  link_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (br_kind == 2'd1 && !stall) |=> (link_data == $past(cur_pc) + W'(8)));

  // R8
  stall_nolink_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> !link_we);

  // R4
  bl_target_chk: assert property (@(posedge clk) disable iff (rst)
    (br_kind == 2'd1 && !stall) |=> (nxt_pc == $past(cur_pc) + $past(br_disp)));
endmodule

// File: tb/test_dbr_pc_unit.sv
module test_dbr_pc_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RV = 32'h0000_1000;

  typedef struct packed {
    logic        stall;
    logic [1:0]  kind;
    logic [31:0] disp;
    logic [31:0] vreg;
    logic [31:0] imm;
    logic [31:0] creg;
    logic [31:0] ecur;
    logic [31:0] enxt;
    logic        ewe;
    logic [31:0] eld;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    // R2 plain step
    '{1'b0, 2'd0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h1004, 32'h1008, 1'b0, 32'h0},
    // R4 R5 branch-and-link at 1004
    '{1'b0, 2'd1, 32'h40, 32'h0, 32'h0, 32'h0, 32'h1008, 32'h1044, 1'b1, 32'h100C},
    // R3 delay slot runs, then target
    '{1'b0, 2'd0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h1044, 32'h1048, 1'b0, 32'h0},
    // R8 stall with a link request
    '{1'b1, 2'd1, 32'h40, 32'h0, 32'h0, 32'h0, 32'h1044, 32'h1048, 1'b0, 32'h0},
    // R7 equal operands, not taken
    '{1'b0, 2'd3, 32'h40, 32'h0, 32'h5, 32'h5, 32'h1048, 32'h104C, 1'b0, 32'h0},
    // R7 unequal, taken backwards
    '{1'b0, 2'd3, 32'hFFFF_FFF8, 32'h0, 32'h5, 32'h6, 32'h104C, 32'h1040, 1'b0, 32'h0},
    // R6 R9 vectored in delay slot, low bits masked
    '{1'b0, 2'd2, 32'h0, 32'h2003, 32'h0, 32'h0, 32'h1040, 32'h2000, 1'b0, 32'h0},
    '{1'b0, 2'd0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h2000, 32'h2004, 1'b0, 32'h0},
    // R6 vectored return
    '{1'b0, 2'd2, 32'h0, 32'h100C, 32'h0, 32'h0, 32'h2004, 32'h100C, 1'b0, 32'h0},
    // R9 R5 link branch in delay slot of vectored branch
    '{1'b0, 2'd1, 32'h8, 32'h0, 32'h0, 32'h0, 32'h100C, 32'h200C, 1'b1, 32'h200C},
    '{1'b0, 2'd0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h200C, 32'h2010, 1'b0, 32'h0}
  };

  logic        clk = 1'b0;
  logic        rst, stall;
  logic [1:0]  br_kind;
  logic [31:0] br_disp, br_reg, cmp_imm, cmp_reg;
  logic [31:0] fetch_pc, cur_pc, nxt_pc, link_data;
  logic        link_we;
  logic [4:0]  link_idx;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbr_pc_unit #(.RESET_VEC(RV)) i_dbr_pc_unit (
    .clk(clk), .rst(rst), .stall(stall), .br_kind(br_kind),
    .br_disp(br_disp), .br_reg(br_reg), .cmp_imm(cmp_imm), .cmp_reg(cmp_reg),
    .fetch_pc(fetch_pc), .cur_pc(cur_pc), .nxt_pc(nxt_pc),
    .link_we(link_we), .link_idx(link_idx), .link_data(link_data)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input logic s, input logic [1:0] k, input logic [31:0] d,
                       input logic [31:0] v, input logic [31:0] i, input logic [31:0] c);
    stall = s; br_kind = k; br_disp = d; br_reg = v; cmp_imm = i; cmp_reg = c;
  endtask

  initial begin
    rst = 1'b1;
    drive(1'b0, 2'd0, '0, '0, '0, '0);
    @(posedge clk); @(posedge clk); #1;
    chk("R1 cur", cur_pc, RV);
    chk("R1 nxt", nxt_pc, RV + 32'd4);
    chk("R1 we", {31'b0, link_we}, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    for (int n = 0; n < NV; n++) begin
      drive(VEC[n].stall, VEC[n].kind, VEC[n].disp, VEC[n].vreg, VEC[n].imm, VEC[n].creg);
      @(posedge clk); #1;
      chk($sformatf("R3 cur v%0d", n), cur_pc, VEC[n].ecur);
      chk($sformatf("R2/R4/R6/R7 nxt v%0d", n), nxt_pc, VEC[n].enxt);
      chk($sformatf("R10 fetch v%0d", n), fetch_pc, VEC[n].enxt);
      chk($sformatf("R5/R8 we v%0d", n), {31'b0, link_we}, {31'b0, VEC[n].ewe});
      if (VEC[n].ewe) begin
        chk($sformatf("R5 data v%0d", n), link_data, VEC[n].eld);
        chk($sformatf("R5 idx v%0d", n), {27'b0, link_idx}, 32'd2);
      end
      @(negedge clk);
    end

    // R8: two stalled cycles in a row, link request held
    drive(1'b1, 2'd1, 32'h100, '0, '0, '0);
    @(posedge clk); @(posedge clk); #1;
    chk("R8 hold cur", cur_pc, 32'h200C);
    chk("R8 hold nxt", nxt_pc, 32'h2010);
    chk("R8 no link", {31'b0, link_we}, 32'd0);
    @(negedge clk);

    // R5: link strobe lasts one cycle
    drive(1'b0, 2'd1, 32'h100, '0, '0, '0);
    @(posedge clk); #1;
    chk("R5 pulse on", {31'b0, link_we}, 32'd1);
    chk("R5 data", link_data, 32'h2014);
    @(negedge clk);
    drive(1'b0, 2'd0, '0, '0, '0, '0);
    @(posedge clk); #1;
    chk("R5 pulse off", {31'b0, link_we}, 32'd0);
    chk("R3 slot then target", cur_pc, 32'h210C);
    @(negedge clk);

    // R1: reset in mid-run
    rst = 1'b1;
    @(posedge clk); #1;
    chk("R1 rerun cur", cur_pc, RV);
    chk("R1 rerun nxt", nxt_pc, RV + 32'd4);
    @(negedge clk);
    rst = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule